// File: doc/BRIEF.md
# Shared-Line Serial Message Node

This block is one node on a two-line message bus that several nodes share. One line carries the bus clock, which the node sees as a one-cycle `busTick` strobe. The other line is an open-drain data line, modelled as a wired-AND: each node has a pull-low enable, and every node samples the resolved level. All nodes step the same bus state sequence. The sequence runs idle, then thirty-two data states, then a release state, an acknowledge state and a completion state, and then returns to idle. Arbitration and the opening address phase are outside this block. A shared `busStart` input stands in for them and moves every node from idle into the data phase.

The node whose processor requested a transfer becomes the master when the transfer starts. It drives its 32-bit shift register onto the line, most significant bit first. Every node that is not deaf shifts the line into its own register, and the master does this too. A node that still holds an unread message when a transfer starts goes deaf for that transfer. In the acknowledge state, a node whose received top three bits equal its local address pulls the line low. The master samples the line when it leaves the acknowledge state and flags a missing acknowledge. The addressed node flags that a message is waiting. The processor reaches the shift register and the flags through a small byte-wide register port.

Top module: `msgbus_node`

## Requirements
- R1: The bus state reads at register 5 as a one-hot code: idle 0x01, data 0x08, release 0x10, acknowledge 0x20, done 0x40. It advances only on a `busTick` cycle. Idle moves to data when `busStart` is high. Data lasts exactly 32 ticks, and the states then run release, acknowledge, done and back to idle.
- R2: The master is the node whose request was pending at the start tick. In data states it pulls the line low exactly when bit 31 of its shift register is 0.
- R3: On every tick in a data state, a node that is not deaf shifts left and takes the line level into bit 0. At the end of the data phase, the first bit sent sits in bit 31.
- R4: A node whose read-pending flag is set at the start tick is deaf for that transfer. Its shift register is unchanged, it does not acknowledge, and read-pending is not set again. Deaf shows as status (register 4) bit 2 and clears on the return to idle.
- R5: A node pulls the line low outside the data states only in the acknowledge state, and only when it is not deaf and shift-register bits 31:29 equal `localAddr`. In idle, release and done, the line is released.
- R6: On the tick that leaves the acknowledge state, the master copies the line level into the not-acknowledged flag (status bit 1): high sets it, low clears it. Writing register 4 with bit 1 set clears the flag.
- R7: On the tick that leaves the acknowledge state, an addressed node that is not deaf sets read-pending (status bit 0).
- R8: Read-pending clears in the cycle after a read strobe of register 3, which holds shift-register bits 31:24. Reading registers 0 to 2 leaves the flag set.
- R9: `irq` is high exactly when read-pending or not-acknowledged is set.
- R10: Registers 0 to 3 write shift-register bytes (register 0 holds bits 7:0) in the idle state only. Such writes are ignored in every other state. In idle, writing register 4 with bit 7 set raises the request flag (status bit 3, `txReq`), and the request clears at the start tick.
- R11: After reset the state is idle, all flags are clear, the shift register is zero, and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Node clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busTick | input | 1 | One-cycle strobe marking a rising bus clock edge |
| busStart | input | 1 | Shared start of a transfer, honoured in idle |
| sdaIn | input | 1 | Resolved level of the shared data line |
| sdaLowEn | output | 1 | Pull the data line low |
| localAddr | input | 3 | This node's bus address |
| regAddr | input | 3 | Register select: 0..3 shift bytes, 4 status/control, 5 state |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational from `regAddr` |
| txReq | output | 1 | Transfer request pending |
| irq | output | 1 | Interrupt: read-pending or not-acknowledged |

## Verification
The bench targets four hazards. The first is a deaf node, which would overwrite an unread message or acknowledge a second time if the flag were ignored. The second is the exact tick on which the not-acknowledged flag is sampled: an off-by-one there would report acknowledged transfers as failed. The third is the side effect of reading the top byte, which would lose a message if any byte read cleared read-pending. The fourth is a shift-register write during a transfer, which would corrupt the bits a master is sending. The bench also runs random transfers in both roles, with and without an address match and with and without an outside acknowledge, and checks the line, the flags and the captured word against a bench model.

// File: rtl/msgbus_pkg.sv
package msgbus_pkg;

  typedef enum logic [6:0] {
    ST_IDLE = 7'h01,
    ST_DATA = 7'h08,
    ST_REL  = 7'h10,
    ST_ACK  = 7'h20,
    ST_DONE = 7'h40
  } busState_e;

  typedef struct packed {
    logic shiftEn;
    logic wrEn;
  } dpCtl_t;

  localparam int REG_STATUS = 4;
  localparam int REG_STATE  = 5;

endpackage

// File: rtl/msgbus_ctrl.sv
module msgbus_ctrl
  import msgbus_pkg::*;
#(
  parameter int MSG_BITS = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      busTick,
  input  logic      busStart,
  input  logic      sdaIn,
  input  logic      srMsb,
  input  logic      addrMatch,
  input  logic      statusWr,
  input  logic      goBit,
  input  logic      nackClrBit,
  input  logic      topByteRd,
  output dpCtl_t    ctl,
  output logic      sdaLowEn,
  output logic      irq,
  output logic      txReq,
  output logic      deafOut,
  output logic [7:0] statusByte,
  output busState_e stateOut
);

  localparam int CNT_W = $clog2(MSG_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(MSG_BITS - 1);

  busState_e        state;
  logic [CNT_W-1:0] bitCnt;
  logic             master;
  logic             deaf;
  logic             request;
  logic             readPending;
  logic             nack;
  logic             startNow;
  logic             ackTick;

  assign startNow = busTick && (state == ST_IDLE) && busStart;
  assign ackTick  = busTick && (state == ST_ACK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      master      <= 1'b0;
      deaf        <= 1'b0;
      request     <= 1'b0;
      readPending <= 1'b0;
      nack        <= 1'b0;
    end else begin
      // processor side first; bus events below take priority
      if (statusWr && nackClrBit) nack <= 1'b0;
      if (statusWr && goBit && (state == ST_IDLE) && !startNow) request <= 1'b1;
      if (topByteRd) readPending <= 1'b0;

      if (busTick) begin
        unique case (state)
          ST_IDLE: if (busStart) begin
            state   <= ST_DATA;
            bitCnt  <= '0;
            master  <= request;
            request <= 1'b0;
            deaf    <= readPending;
          end
          ST_DATA: begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) state <= ST_REL;
          end
          ST_REL: state <= ST_ACK;
          ST_ACK: begin
            state <= ST_DONE;
            if (master) nack <= sdaIn;
            if (!deaf && addrMatch) readPending <= 1'b1;
          end
          ST_DONE: begin
            state  <= ST_IDLE;
            master <= 1'b0;
            deaf   <= 1'b0;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    sdaLowEn = 1'b0;
    unique case (state)
      ST_DATA: sdaLowEn = master && !srMsb;
      ST_ACK:  sdaLowEn = !deaf && addrMatch;
      default: sdaLowEn = 1'b0;
    endcase
  end

  assign ctl.shiftEn = busTick && (state == ST_DATA) && !deaf;
  assign ctl.wrEn    = (state == ST_IDLE);
  assign irq         = readPending || nack;
  assign txReq       = request;
  assign deafOut     = deaf;
  assign statusByte  = {4'b0000, request, deaf, nack, readPending};
  assign stateOut    = state;

  assert_rel_to_ack_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REL && busTick) |=> (state == ST_ACK));
  assert_done_to_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && busTick) |=> (state == ST_IDLE));
  assert_hold_no_tick_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busTick |=> $stable(state));
  assert_recv_drive_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sdaLowEn && !master) |-> (state == ST_ACK && addrMatch && !deaf));
  assert_nack_sample_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ackTick && master) |=> (nack == $past(sdaIn)));
  assert_rp_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (topByteRd && !ackTick) |=> !readPending);

endmodule

// File: rtl/msgbus_dp.sv
module msgbus_dp
  import msgbus_pkg::*;
#(
  parameter int MSG_BITS  = 32,
  parameter int ADDR_BITS = 3,
  parameter int REG_AW    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  logic                 sdaIn,
  input  logic [ADDR_BITS-1:0] localAddr,
  input  logic                 regWr,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [7:0]           regWdata,
  input  logic [7:0]           statusByte,
  input  logic [6:0]           stateCode,
  output logic [7:0]           regRdata,
  output logic                 srMsb,
  output logic                 addrMatch
);

  localparam int N_BYTES = MSG_BITS / 8;

  logic [MSG_BITS-1:0] sr;
  logic [N_BYTES-1:0]  byteSel;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_lane
    assign byteSel[b] = regWr && ctl.wrEn && (regAddr == REG_AW'(b));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sr <= '0;
    end else if (ctl.shiftEn) begin
      sr <= {sr[MSG_BITS-2:0], sdaIn};
    end else begin
      for (int b = 0; b < N_BYTES; b++) begin
        if (byteSel[b]) sr[b*8 +: 8] <= regWdata;
      end
    end
  end

  always_comb begin
    regRdata = 8'h00;
    for (int b = 0; b < N_BYTES; b++) begin
      if (regAddr == REG_AW'(b)) regRdata = sr[b*8 +: 8];
    end
    if (regAddr == REG_AW'(REG_STATUS)) regRdata = statusByte;
    if (regAddr == REG_AW'(REG_STATE))  regRdata = {1'b0, stateCode};
  end

  assign srMsb     = sr[MSG_BITS-1];
  assign addrMatch = (sr[MSG_BITS-1 -: ADDR_BITS] == localAddr);

  assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftEn |=> (sr[0] == $past(sdaIn)));
  assert_no_write_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.wrEn && !ctl.shiftEn) |=> $stable(sr));

endmodule

// File: rtl/msgbus_node.sv
module msgbus_node
  import msgbus_pkg::*;
#(
  parameter int MSG_BITS  = 32,
  parameter int ADDR_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busTick,
  input  logic                 busStart,
  input  logic                 sdaIn,
  output logic                 sdaLowEn,
  input  logic [ADDR_BITS-1:0] localAddr,
  input  logic [2:0]           regAddr,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic [7:0]           regWdata,
  output logic [7:0]           regRdata,
  output logic                 txReq,
  output logic                 irq
);

  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] TOP_BYTE = REG_AW'(MSG_BITS / 8 - 1);

  dpCtl_t     ctl;
  logic       srMsb;
  logic       addrMatch;
  logic       deaf;
  logic [7:0] statusByte;
  busState_e  state;
  logic       statusWr;
  logic       topByteRd;

  assign statusWr  = regWr && (regAddr == REG_AW'(REG_STATUS));
  assign topByteRd = regRd && (regAddr == TOP_BYTE);

  msgbus_ctrl #(.MSG_BITS(MSG_BITS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busTick    (busTick),
    .busStart   (busStart),
    .sdaIn      (sdaIn),
    .srMsb      (srMsb),
    .addrMatch  (addrMatch),
    .statusWr   (statusWr),
    .goBit      (regWdata[7]),
    .nackClrBit (regWdata[1]),
    .topByteRd  (topByteRd),
    .ctl        (ctl),
    .sdaLowEn   (sdaLowEn),
    .irq        (irq),
    .txReq      (txReq),
    .deafOut    (deaf),
    .statusByte (statusByte),
    .stateOut   (state)
  );

  msgbus_dp #(.MSG_BITS(MSG_BITS), .ADDR_BITS(ADDR_BITS), .REG_AW(REG_AW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .sdaIn      (sdaIn),
    .localAddr  (localAddr),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .statusByte (statusByte),
    .stateCode  (state),
    .regRdata   (regRdata),
    .srMsb      (srMsb),
    .addrMatch  (addrMatch)
  );

  assert_deaf_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (deaf && state == ST_DATA) |=> ($stable(srMsb) && $stable(addrMatch)));

endmodule

// File: tb/msgbus_node_bench.sv
`timescale 1ns/1ps
module msgbus_node_bench;

  localparam logic [2:0] MY_ADDR = 3'd5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busTick = 1'b0, busStart = 1'b0, benchLow = 1'b0;
  logic sdaLowEn, sdaIn, txReq, irq;
  logic [2:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0, regRdata;

  int checks = 0, errors = 0;
  logic [31:0] modelSr = '0;
  logic modelRp = 1'b0, modelNack = 1'b0;

  always #4 clk = ~clk;
  assign sdaIn = ~(sdaLowEn | benchLow);

  msgbus_node u_msgbus_node (
    .clk(clk), .rstN(rstN), .busTick(busTick), .busStart(busStart),
    .sdaIn(sdaIn), .sdaLowEn(sdaLowEn), .localAddr(MY_ADDR),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .txReq(txReq), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expStatus(input logic rq, input logic df);
    return {4'b0000, rq, df, modelNack, modelRp};
  endfunction

  task automatic tick();
    busTick = 1'b1;
    @(posedge clk); @(negedge clk);
    busTick = 1'b0;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(posedge clk); @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(posedge clk); @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic loadSr(input logic [31:0] w);
    for (int b = 0; b < 4; b++) regWrite(3'(b), w[b*8 +: 8]);
    modelSr = w;
  endtask

  task automatic readSr(output logic [31:0] w);
    logic [7:0] d;
    for (int b = 0; b < 4; b++) begin
      regRead(3'(b), d);
      w[b*8 +: 8] = d;
    end
    modelRp = 1'b0;
  endtask

  task automatic checkState(input logic [7:0] exp, input string what);
    logic [7:0] d;
    regRead(3'd5, d);
    check(d == exp, "R1", what, 32'(d), 32'(exp));
  endtask

  // One full transfer; bench model updated from the requirements.
  task automatic runXfer(input bit dutMaster, input logic [31:0] benchWord,
                         input bit benchAck, input bit midWrite);
    logic [31:0] word;
    logic [7:0] d;
    bit deafExp, matchExp, driveBad;
    deafExp = modelRp;
    driveBad = 1'b0;
    if (dutMaster) begin
      regWrite(3'd4, 8'h80);
      check(txReq == 1'b1, "R10", "txReq after go", 32'(txReq), 32'd1);
      word = modelSr;
    end else begin
      word = benchWord;
    end
    busStart = 1'b1; tick(); busStart = 1'b0;
    check(txReq == 1'b0, "R10", "request cleared at start", 32'(txReq), 32'd0);
    checkState(8'h08, "data state code");
    if (midWrite) regWrite(3'd0, ~word[7:0]);
    for (int i = 0; i < 32; i++) begin
      if (dutMaster) begin
        if (sdaLowEn != ~word[31-i]) driveBad = 1'b1;
      end else begin
        benchLow = ~word[31-i];
        if (sdaLowEn) driveBad = 1'b1;
      end
      if (i == 16) begin
        regRead(3'd4, d);
        check(d[2] == deafExp, "R4", "deaf status bit", 32'(d[2]), 32'(deafExp));
      end
      tick();
    end
    benchLow = 1'b0;
    check(!driveBad, "R2", "data line driving", 32'(driveBad), 32'd0);
    checkState(8'h10, "release state code");
    check(sdaLowEn == 1'b0, "R5", "released in release state", 32'(sdaLowEn), 32'd0);
    tick();
    checkState(8'h20, "ack state code");
    if (!deafExp) modelSr = word;
    matchExp = !deafExp && (modelSr[31:29] == MY_ADDR);
    check(sdaLowEn == matchExp, "R5", "ack drive", 32'(sdaLowEn), 32'(matchExp));
    benchLow = benchAck;
    tick();
    benchLow = 1'b0;
    if (matchExp) modelRp = 1'b1;
    if (dutMaster) modelNack = !(benchAck || matchExp);
    checkState(8'h40, "done state code");
    check(sdaLowEn == 1'b0, "R5", "released in done state", 32'(sdaLowEn), 32'd0);
    regRead(3'd4, d);
    check(d == expStatus(1'b0, deafExp), "R6", "flags after ack", 32'(d),
          32'(expStatus(1'b0, deafExp)));
    tick();
    checkState(8'h01, "back to idle");
    regRead(3'd4, d);
    check(d == expStatus(1'b0, 1'b0), "R7", "status in idle (deaf cleared R4)",
          32'(d), 32'(expStatus(1'b0, 1'b0)));
    check(irq == (modelRp | modelNack), "R9", "irq", 32'(irq), 32'(modelRp | modelNack));
  endtask

  task automatic checkSr(input string req);
    logic [31:0] w;
    readSr(w);
    check(w == modelSr, req, "shift register contents", w, modelSr);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic [31:0] w;
    int seedInit;
    seedInit = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    checkState(8'h01, "reset idle (R11)");
    regRead(3'd4, d);
    check(d == 8'h00, "R11", "reset status", 32'(d), 32'd0);
    check(irq == 1'b0 && sdaLowEn == 1'b0 && txReq == 1'b0, "R11", "reset outputs",
          {29'd0, irq, sdaLowEn, txReq}, 32'd0);
    readSr(w);
    check(w == 32'd0, "R11", "reset shift register", w, 32'd0);

    // R1: no advance without tick even with start high
    busStart = 1'b1; repeat (3) @(negedge clk); busStart = 1'b0;
    checkState(8'h01, "no tick no advance");

    // Receiver, address match (R3, R5, R7)
    runXfer(1'b0, 32'hA5C3_1E77, 1'b0, 1'b0);
    check(irq == 1'b1, "R9", "irq on read pending", 32'(irq), 32'd1);
    // R8: low bytes do not clear, top byte does
    regRead(3'd0, d); regRead(3'd1, d); regRead(3'd2, d);
    regRead(3'd4, d);
    check(d[0] == 1'b1, "R8", "rp kept after low byte reads", 32'(d[0]), 32'd1);
    regRead(3'd3, d);
    check(d == 8'hA5, "R3", "top byte", 32'(d), 32'hA5);
    modelRp = 1'b0;
    regRead(3'd4, d);
    check(d[0] == 1'b0, "R8", "rp cleared after top byte read", 32'(d[0]), 32'd0);
    checkSr("R3");

    // Receiver, mismatch: captured, no ack
    runXfer(1'b0, 32'h3344_5566, 1'b0, 1'b0);
    checkSr("R3");

    // Deaf: leave message unread, second transfer ignored (R4)
    runXfer(1'b0, 32'hBEEF_0001, 1'b0, 1'b0);
    runXfer(1'b0, 32'h1234_5678, 1'b0, 1'b0);
    checkSr("R4");

    // Master, no acknowledge -> nack (R6), then W1C
    loadSr(32'h1357_9BDF);
    runXfer(1'b1, 32'd0, 1'b0, 1'b0);
    check(irq == 1'b1, "R9", "irq on nack", 32'(irq), 32'd1);
    regWrite(3'd4, 8'h02); modelNack = 1'b0;
    regRead(3'd4, d);
    check(d[1] == 1'b0, "R6", "nack write-one clear", 32'(d[1]), 32'd0);

    // Master, acknowledged, mid-transfer write ignored (R10)
    loadSr(32'h6B00_FF11);
    runXfer(1'b1, 32'd0, 1'b1, 1'b1);
    checkSr("R10");

    // Go ignored outside idle (R10)
    busStart = 1'b1; tick(); busStart = 1'b0;
    regWrite(3'd4, 8'h80);
    check(txReq == 1'b0, "R10", "go ignored mid transfer", 32'(txReq), 32'd0);
    for (int i = 0; i < 35; i++) tick();
    modelSr = 32'hFFFF_FFFF;
    checkState(8'h01, "idle after bare transfer");
    checkSr("R3");

    // Random transfers
    for (int n = 0; n < 24; n++) begin
      bit dm, ack, rd;
      logic [31:0] rw;
      dm  = 1'($urandom % 2);
      ack = 1'($urandom % 2);
      rd  = ($urandom % 4) != 0;
      rw  = $urandom;
      if (($urandom % 2) == 0) rw[31:29] = MY_ADDR;
      if (dm) begin
        if (modelRp) readSr(w);
        loadSr(rw);
        runXfer(1'b1, 32'd0, ack, 1'b0);
        if (modelNack) begin regWrite(3'd4, 8'h02); modelNack = 1'b0; end
      end else begin
        runXfer(1'b0, rw, 1'b0, 1'b0);
      end
      if (rd) checkSr("R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule